// File: doc/BRIEF.md
# Overlay Memory Region Decoder with Wait States

This block sits between a DSP core's address generators and its memories. For each access it takes the 14-bit address, whether the access targets program space or data space, the read and write strobes, a boot-mode pin, and the overlay numbers for each space. From these it picks one target: internal program RAM, external program overlay, internal data RAM, external data overlay, the control-register window, or reserved space. It drives one chip-select for the target. An access to reserved space raises an error flag instead.

Internal RAM and control-register accesses finish in the cycle they are presented. External accesses stall the core for the number of wait states in a 3-bit wait-state field. The ready output tells the core when the access completes, and the wait counter output shows how many stall cycles remain. While an access is stalled, the decoder keeps the selected target latched, so changes on the inputs during the stall have no effect. The program word is 24 bits and the data word is 16 bits. Those widths belong to the memory arrays and do not enter the decode.

Top module: `mem_region_decoder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), and in every idle cycle after it, `ready`=1, `wait_cnt`=0, `err`=0 and all chip-selects are 0. This holds even if the reset arrives in the middle of a stall.
- R2: With `boot_ext`=0, a program access (`sel_dm`=0) to 0x0000–0x1FFF asserts `cs_int_pm`.
- R3: With `boot_ext`=0, a program access to 0x2000–0x3FFF asserts `cs_ext_pm` when `pm_ovl` is 1 or 2. When `pm_ovl` is 0 or 3 it is reserved.
- R4: With `boot_ext`=1, a program access to 0x0000–0x1FFF asserts `cs_ext_pm`, and a program access to 0x2000–0x3FFF is reserved.
- R5: A data access (`sel_dm`=1) to 0x0000–0x1FFF asserts `cs_int_dm`.
- R6: A data access to 0x2000–0x2FFF asserts `cs_ext_dm` when `dm_ovl` is 1 or 2. When `dm_ovl` is 0 or 3 it is reserved.
- R7: A data access to 0x3000–0x3FDF is reserved.
- R8: A data access to 0x3FE0–0x3FFF asserts `cs_ctrl`.
- R9: An internal RAM or control-register access keeps `ready` high in its single cycle. The same is true of an external access with `ws_cfg`=0.
- R10: An external access with `ws_cfg`=N>0 occupies N+1 cycles. `ready` is low for the first N cycles and high in the last one. `wait_cnt` reads 0 in the first cycle, then N-1 down to 0. The external chip-select stays asserted in every cycle of the access.
- R11: A reserved access asserts `err` for that one cycle, asserts no chip-select, and keeps `ready` high.
- R12: With both `rd` and `wr` low and no stall in progress, no chip-select and no `err` are asserted, whatever the address.
- R13: During a stall, changes on `addr`, `sel_dm`, the overlay inputs, `boot_ext` and `ws_cfg` change neither the asserted chip-select nor the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 14 | Access address |
| sel_dm | input | 1 | 1 = data space, 0 = program space |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| boot_ext | input | 1 | Mode pin: 1 maps the lower program half to external memory |
| pm_ovl | input | 2 | Program overlay number |
| dm_ovl | input | 2 | Data overlay number |
| ws_cfg | input | 3 | Wait states for external accesses (0–7) |
| cs_int_pm | output | 1 | Internal program RAM select |
| cs_ext_pm | output | 1 | External program overlay select |
| cs_int_dm | output | 1 | Internal data RAM select |
| cs_ext_dm | output | 1 | External data overlay select |
| cs_ctrl | output | 1 | Control-register window select |
| ready | output | 1 | Access completes this cycle |
| err | output | 1 | Reserved-space access flag |
| wait_cnt | output | 3 | Remaining wait cycles of the current stall |

## Verification
The bench sweeps every region boundary (0x1FFF/0x2000, 0x2FFF/0x3000, 0x3FDF/0x3FE0) under both mode-pin values and all four overlay numbers. An off-by-one comparator would select the wrong chip-select at one of these edges. It would also fail to flag overlay 0 or 3 as reserved. Wait values of 0, 1 and 7 catch a stall that is one cycle too long or too short, and a zero-wait external access that stalls when it should not. Changing every input during a stall exposes a design that decodes live instead of holding its target. A reset in the middle of a stall shows whether the stall state clears.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W = 14;
    localparam int WS_W   = 3;
    localparam int OVL_W  = 2;

    localparam logic [ADDR_W-1:0] UPPER_HALF = 14'h2000;
    localparam logic [ADDR_W-1:0] DM_RSV_LO  = 14'h3000;
    localparam logic [ADDR_W-1:0] CTRL_LO    = 14'h3FE0;

    typedef enum logic [2:0] {
        RG_NONE   = 3'd0,
        RG_INT_PM = 3'd1,
        RG_EXT_PM = 3'd2,
        RG_INT_DM = 3'd3,
        RG_EXT_DM = 3'd4,
        RG_CTRL   = 3'd5,
        RG_RESV   = 3'd6
    } region_e;

    typedef struct packed {
        logic int_pm;
        logic ext_pm;
        logic int_dm;
        logic ext_dm;
        logic ctrl;
    } sel_t;

    function automatic logic ovl_is_ext(input logic [OVL_W-1:0] ovl);
        return (ovl == 2'd1) || (ovl == 2'd2);
    endfunction

    function automatic logic region_is_ext(input region_e r);
        return (r == RG_EXT_PM) || (r == RG_EXT_DM);
    endfunction

    function automatic sel_t region_to_sel(input region_e r);
        sel_t s;
        s = '0;
        case (r)
            RG_INT_PM: s.int_pm = 1'b1;
            RG_EXT_PM: s.ext_pm = 1'b1;
            RG_INT_DM: s.int_dm = 1'b1;
            RG_EXT_DM: s.ext_dm = 1'b1;
            RG_CTRL:   s.ctrl   = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode
    import ovl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OVL_W
) (
    input  logic [AW-1:0] addr,
    input  logic          sel_dm,
    input  logic          boot_ext,
    input  logic [OW-1:0] pm_ovl,
    input  logic [OW-1:0] dm_ovl,
    output region_e       region
);
    logic upper;
    assign upper = (addr >= UPPER_HALF);

    always_comb begin
        region = RG_RESV;
        if (!sel_dm) begin
            if (boot_ext) begin
                region = upper ? RG_RESV : RG_EXT_PM;
            end else if (!upper) begin
                region = RG_INT_PM;
            end else begin
                region = ovl_is_ext(pm_ovl) ? RG_EXT_PM : RG_RESV;
            end
        end else begin
            if (!upper) begin
                region = RG_INT_DM;
            end else if (addr < DM_RSV_LO) begin
                region = ovl_is_ext(dm_ovl) ? RG_EXT_DM : RG_RESV;
            end else if (addr < CTRL_LO) begin
                region = RG_RESV;
            end else begin
                region = RG_CTRL;
            end
        end
    end
endmodule

// File: rtl/ovl_wait_timer.sv
module ovl_wait_timer #(
    parameter int WW = ovl_pkg::WS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [WW-1:0] ws,
    output logic          busy,
    output logic [WW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start && (ws != '0)) begin
            busy <= 1'b1;
            cnt  <= ws - 1'b1;
        end
    end
endmodule

// File: rtl/ovl_sel_hold.sv
module ovl_sel_hold
    import ovl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    capture,
    input  logic    busy,
    input  logic    req,
    input  region_e region_in,
    output region_e active
);
    region_e held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= RG_NONE;
        end else if (capture) begin
            held <= region_in;
        end
    end

    always_comb begin
        if (busy)     active = held;
        else if (req) active = region_in;
        else          active = RG_NONE;
    end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_dm,
    input  logic              rd,
    input  logic              wr,
    input  logic              boot_ext,
    input  logic [OVL_W-1:0]  pm_ovl,
    input  logic [OVL_W-1:0]  dm_ovl,
    input  logic [WS_W-1:0]   ws_cfg,
    output logic              cs_int_pm,
    output logic              cs_ext_pm,
    output logic              cs_int_dm,
    output logic              cs_ext_dm,
    output logic              cs_ctrl,
    output logic              ready,
    output logic              err,
    output logic [WS_W-1:0]   wait_cnt
);
    logic    req;
    logic    busy;
    logic    ext_start;
    logic    stall_start;
    region_e dec_region;
    region_e act_region;
    sel_t    sel;
    logic [WS_W-1:0] cnt;

    assign req = rd | wr;

    ovl_addr_decode #(.AW(ADDR_W), .OW(OVL_W)) u_dec (
        .addr     (addr),
        .sel_dm   (sel_dm),
        .boot_ext (boot_ext),
        .pm_ovl   (pm_ovl),
        .dm_ovl   (dm_ovl),
        .region   (dec_region)
    );

    assign ext_start   = !busy && req && region_is_ext(dec_region);
    assign stall_start = ext_start && (ws_cfg != '0);

    ovl_wait_timer #(.WW(WS_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (ext_start),
        .ws    (ws_cfg),
        .busy  (busy),
        .cnt   (cnt)
    );

    ovl_sel_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .capture   (stall_start),
        .busy      (busy),
        .req       (req),
        .region_in (dec_region),
        .active    (act_region)
    );

    assign sel       = region_to_sel(act_region);
    assign cs_int_pm = sel.int_pm;
    assign cs_ext_pm = sel.ext_pm;
    assign cs_int_dm = sel.int_dm;
    assign cs_ext_dm = sel.ext_dm;
    assign cs_ctrl   = sel.ctrl;

    assign err      = (act_region == RG_RESV);
    assign ready    = busy ? (cnt == '0) : !stall_start;
    assign wait_cnt = cnt;
endmodule

// File: rtl/mem_region_decoder_chk.sv
module mem_region_decoder_chk #(
    parameter int WW = ovl_pkg::WS_W
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_int_pm,
    input logic          cs_ext_pm,
    input logic          cs_int_dm,
    input logic          cs_ext_dm,
    input logic          cs_ctrl,
    input logic          ready,
    input logic          err,
    input logic [WW-1:0] wait_cnt
);
    logic [4:0] cs_all;
    assign cs_all = {cs_int_pm, cs_ext_pm, cs_int_dm, cs_ext_dm, cs_ctrl};

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_all)); // R2

    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        err |-> (cs_all == 5'd0) && ready); // R11

    AST_FAST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (cs_int_pm || cs_int_dm || cs_ctrl) |-> ready); // R9

    AST_COUNT_HOLDS_READY: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt != '0) |-> !ready); // R10

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt != '0) |=> (wait_cnt == WW'($past(wait_cnt) - 1'b1))); // R10

    AST_STALL_KEEPS_EXT: assert property (@(posedge clk) disable iff (rst)
        (!ready && cs_ext_pm) |=> cs_ext_pm); // R13
endmodule

bind mem_region_decoder mem_region_decoder_chk #(.WW(ovl_pkg::WS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_int_pm (cs_int_pm),
    .cs_ext_pm (cs_ext_pm),
    .cs_int_dm (cs_int_dm),
    .cs_ext_dm (cs_ext_dm),
    .cs_ctrl   (cs_ctrl),
    .ready     (ready),
    .err       (err),
    .wait_cnt  (wait_cnt)
);

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] addr = '0;
    logic        sel_dm = 1'b0, rd = 1'b0, wr = 1'b0, boot_ext = 1'b0;
    logic [1:0]  pm_ovl = '0, dm_ovl = '0;
    logic [2:0]  ws_cfg = '0;
    logic        cs_int_pm, cs_ext_pm, cs_int_dm, cs_ext_dm, cs_ctrl, ready, err;
    logic [2:0]  wait_cnt;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";
    int m_busy = 0;
    int m_cnt = 0;
    int m_held = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mem_region_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .sel_dm(sel_dm), .rd(rd), .wr(wr),
        .boot_ext(boot_ext), .pm_ovl(pm_ovl), .dm_ovl(dm_ovl), .ws_cfg(ws_cfg),
        .cs_int_pm(cs_int_pm), .cs_ext_pm(cs_ext_pm), .cs_int_dm(cs_int_dm),
        .cs_ext_dm(cs_ext_dm), .cs_ctrl(cs_ctrl), .ready(ready), .err(err),
        .wait_cnt(wait_cnt)
    );

    // region codes: 0 none, 1 int pm, 2 ext pm, 3 int dm, 4 ext dm, 5 ctrl, 6 reserved
    function automatic int ref_region(int a, bit dm, bit md, int po, int dov);
        if (!dm) begin
            if (md) return (a < 8192) ? 2 : 6;
            if (a < 8192) return 1;
            return (po == 1 || po == 2) ? 2 : 6;
        end
        if (a < 8192) return 3;
        if (a < 12288) return (dov == 1 || dov == 2) ? 4 : 6;
        if (a < 16352) return 6;
        return 5;
    endfunction

    function automatic logic [4:0] cs_of(int r);
        case (r)
            1: return 5'b10000;
            2: return 5'b01000;
            3: return 5'b00100;
            4: return 5'b00010;
            5: return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic step(input int a, input bit dm, input bit rdv, input bit wrv,
                        input bit md, input int po, input int dov, input int w);
        int r;
        logic [4:0] e_cs, a_cs;
        bit e_rdy, e_err;
        int e_wc;
        @(negedge clk);
        addr = 14'(a); sel_dm = dm; rd = rdv; wr = wrv; boot_ext = md;
        pm_ovl = 2'(po); dm_ovl = 2'(dov); ws_cfg = 3'(w);
        #5;
        r = (rdv || wrv) ? ref_region(a, dm, md, po, dov) : 0;
        if (m_busy != 0) begin
            e_cs = cs_of(m_held); e_rdy = (m_cnt == 0); e_err = 0; e_wc = m_cnt;
        end else begin
            e_cs = cs_of(r); e_err = (r == 6); e_wc = 0;
            e_rdy = !((r == 2 || r == 4) && w != 0);
        end
        a_cs = {cs_int_pm, cs_ext_pm, cs_int_dm, cs_ext_dm, cs_ctrl};
        total++;
        if (a_cs !== e_cs || ready !== e_rdy || err !== e_err || int'(wait_cnt) != e_wc) begin
            bad++;
            $display("FAIL %s addr=%h dm=%0d: cs=%b rdy=%b err=%b wc=%0d expected cs=%b rdy=%b err=%b wc=%0d",
                     cur_tag, a, dm, a_cs, ready, err, wait_cnt, e_cs, e_rdy, e_err, e_wc);
        end
        @(posedge clk);
        #1;
        if (rst) begin
            m_busy = 0; m_cnt = 0;
        end else if (m_busy != 0) begin
            if (m_cnt == 0) m_busy = 0; else m_cnt--;
        end else if ((r == 2 || r == 4) && w != 0) begin
            m_busy = 1; m_cnt = w - 1; m_held = r;
        end
    endtask

    task automatic access(input int a, input bit dm, input bit isw, input bit md,
                          input int po, input int dov, input int w);
        step(a, dm, !isw, isw, md, po, dov, w);
        while (m_busy != 0) step(a, dm, !isw, isw, md, po, dov, w);
    endtask

    function automatic string tag_for(int a, bit dm, bit md);
        if (!dm) return md ? "R4" : ((a < 8192) ? "R2" : "R3");
        if (a < 8192) return "R5";
        if (a < 12288) return "R6";
        if (a < 16352) return "R7";
        return "R8";
    endfunction

    initial begin
        int addrs[10] = '{0, 100, 8191, 8192, 9000, 12287, 12288, 16351, 16352, 16383};
        int wsl[3] = '{0, 1, 7};
        cur_tag = "R1";
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 0);

        for (int md = 0; md < 2; md++)
            for (int dm = 0; dm < 2; dm++)
                for (int ov = 0; ov < 4; ov++)
                    for (int i = 0; i < 10; i++)
                        for (int k = 0; k < 3; k++) begin
                            cur_tag = tag_for(addrs[i], dm[0], md[0]);
                            access(addrs[i], dm[0], k[0], md[0], ov, ov, wsl[k]);
                        end

        cur_tag = "R9";
        access(16, 0, 0, 0, 0, 0, 7);
        access(16360, 1, 1, 0, 0, 0, 7);
        access(9000, 1, 0, 0, 1, 1, 0);
        cur_tag = "R10";
        for (int w = 1; w < 8; w++) access(4000, 1, w[0], 1, 0, 0, w);
        access(8200, 1, 0, 0, 2, 2, 5);
        cur_tag = "R11";
        access(12400, 1, 0, 0, 0, 0, 7);
        access(9000, 0, 1, 1, 1, 1, 3);
        cur_tag = "R12";
        for (int i = 0; i < 10; i++) step(addrs[i], i[0], 0, 0, i[1], 1, 1, 4);

        cur_tag = "R13";
        step(256, 0, 1, 0, 1, 0, 0, 4);
        step(16370, 1, 1, 0, 0, 0, 0, 7);
        step(100, 1, 0, 1, 0, 3, 3, 1);
        step(12300, 0, 1, 0, 0, 2, 1, 0);
        step(9000, 1, 1, 0, 0, 1, 1, 2);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        cur_tag = "R1";
        step(200, 0, 1, 0, 1, 0, 0, 6);
        step(200, 0, 1, 0, 1, 0, 0, 6);
        rst = 1'b1;
        step(200, 0, 1, 0, 1, 0, 0, 6);
        rst = 1'b0;
        step(200, 0, 0, 0, 1, 0, 0, 6);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule